// File: doc/BRIEF.md
# Packed SIMD Add-Subtract Unit

This block does lane-parallel integer arithmetic on two 32-bit operands. One operation code selects four 8-bit lanes or two 16-bit lanes, signed or unsigned arithmetic, and one of three lane behaviours: wrapping, saturating or halving. Each lane can add or subtract. In 16-bit form there are also two exchange variants. In these, each half of the first operand is combined with the opposite half of the second operand, with an add in one lane and a subtract in the other. The result path is purely combinational.

Wrapping lane operations also produce a 4-bit greater-or-equal vector, with one bit per byte. On a valid cycle this vector is loaded into a small flag register. A separate byte-select operation later reads that stored vector and builds a word byte by byte from the two operands. The operation space also holds a full-width 32-bit signed saturating add and subtract. The surrounding pipeline decodes instructions and supplies operands. It reads the stored flags back through `flags_o`.

Operation code fields: `op_i[5:4]` is the mode (0 wrap, 1 saturate, 2 halve, 3 special), `op_i[3]` is signed, `op_i[2]` selects 16-bit lanes, and `op_i[1:0]` is the kind (0 add, 1 subtract, 2 add-high/subtract-low exchange, 3 subtract-high/add-low exchange). In special mode only the kind field counts: 0 is a 32-bit saturating add, 1 is a 32-bit saturating subtract, 2 is byte select and 3 is reserved.

Top module: `simd_addsub`

## Requirements
- R1: In wrapping 8-bit mode, each byte lane returns the low 8 bits of a[i] plus or minus b[i] (e.g. signed add of 0x87858381 and 0x08060402 gives 0x8F8B8783).
- R2: In 16-bit lanes with kind 2, the top lane is a.hi + b.lo and the bottom lane is a.lo − b.hi. With kind 3, the top lane is a.hi − b.lo and the bottom lane is a.lo + b.hi (wrapping 0x80078003, 0x00040002 under kind 2 gives 0x80097FFF).
- R3: Signed saturating lanes clamp to the most negative value (0x80 / 0x8000) or the most positive value (0x7F / 0x7FFF) instead of wrapping.
- R4: Unsigned saturating lanes clamp to all-ones on overflow and to zero on underflow. An unsigned saturating add never returns a lane smaller than the first operand's lane.
- R5: Halving lanes return the full-precision lane result shifted right by one. The shift is arithmetic for signed lanes (floor), and an unsigned lane keeps its carry or borrow as the new top bit.
- R6: Special kinds 0 and 1 do a 32-bit signed add or subtract that clamps to 0x80000000 or 0x7FFFFFFF.
- R7: Per-lane greater-or-equal: for signed lanes the bit is set when the full result is non-negative. For an unsigned add it is set on carry-out, and for an unsigned subtract it is set when no borrow occurs. Flag bit i belongs to byte i. A 16-bit lane drives both of its byte bits.
- R8: The flag register resets to zero under synchronous active-low reset. `flag_we_o` is high only for a valid, non-reserved wrapping lane operation. The register loads at that clock edge and holds in all other cycles.
- R9: Byte select (special kind 2) takes byte i from `a_i` when stored flag bit i is 1, and from `b_i` when it is 0.
- R10: Reserved codes (special kind 3, and kinds 2 or 3 with 8-bit lanes) give a zero result and never write the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | The operation on the inputs is issued this cycle |
| op_i | input | 6 | Operation code (mode, signed, width, kind) |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| result_o | output | 32 | Combinational result |
| flags_o | output | 4 | Stored greater-or-equal vector |
| flag_we_o | output | 1 | The flag register loads at the next edge |

## Verification
Byte-lane vectors use sign-bit-heavy operands with small addends. These separate signed from unsigned and wrap from clamp in each lane independently. Exchange vectors put different values in the two halves so that swapped operand halves or a swapped add and subtract show up at once. Halving vectors are chosen so that floor rounding, and the carry or borrow kept in unsigned halving, change the result. Flag sequences load known patterns through signed and unsigned wrapping operations, then read them back through byte select. Saturating and reserved operations issued with valid high show that the stored flags stay unchanged.

// File: rtl/simd_pkg.sv
// Shared widths, operation-code layout and enums for the packed SIMD unit.
// Assumes a 32-bit word that splits evenly into byte and halfword lanes.
package simd_pkg;
    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int HALF_W   = 16;
    localparam int BYTE_N   = WORD_W / BYTE_W;
    localparam int HALF_N   = WORD_W / HALF_W;
    localparam int BPH      = HALF_W / BYTE_W;
    localparam int FLAG_W   = BYTE_N;

    typedef enum logic [1:0] {
        MODE_WRAP  = 2'd0,
        MODE_SAT   = 2'd1,
        MODE_HALVE = 2'd2,
        MODE_SPEC  = 2'd3
    } lane_mode_e;

    typedef enum logic [1:0] {
        KIND_ADD = 2'd0,
        KIND_SUB = 2'd1,
        KIND_XAS = 2'd2,
        KIND_XSA = 2'd3
    } lane_kind_e;

    typedef struct packed {
        lane_mode_e mode;
        logic       sgn;
        logic       wide;
        lane_kind_e kind;
    } simd_op_t;

    localparam int OP_W = $bits(simd_op_t);
endpackage

// File: rtl/simd_lane.sv
// One arithmetic lane of width W: add or subtract at full precision, then
// wrap, saturate or halve. Also gives the greater-or-equal bit.
// Assumes the caller selects operands and add/subtract; mode 3 acts as wrap.
module simd_lane
    import simd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         sgn_i,
    input  lane_mode_e   mode_i,
    output logic [W-1:0] res_o,
    output logic         ge_o
);
    localparam int EXT_W = W + 2;

    logic [EXT_W-1:0] ext_a;
    logic [EXT_W-1:0] ext_b;
    logic [EXT_W-1:0] full;
    logic             over_hi;
    logic             over_lo;

    // Extend both operands by two bits and form the exact lane result.
    always_comb begin
        ext_a = {{2{sgn_i & a_i[W-1]}}, a_i};
        ext_b = {{2{sgn_i & b_i[W-1]}}, b_i};
        full  = sub_i ? (ext_a - ext_b) : (ext_a + ext_b);
    end

    // Detect results above the lane maximum or below the lane minimum.
    always_comb begin
        if (sgn_i) begin
            over_hi = ~full[W] &  full[W-1];
            over_lo =  full[W] & ~full[W-1];
        end else begin
            over_hi = ~full[W+1] & full[W];
            over_lo =  full[W+1];
        end
    end

    // Pick the lane output for the requested behaviour.
    always_comb begin
        unique case (mode_i)
            MODE_SAT: begin
                if (over_hi)      res_o = sgn_i ? {1'b0, {(W-1){1'b1}}} : {W{1'b1}};
                else if (over_lo) res_o = sgn_i ? {1'b1, {(W-1){1'b0}}} : {W{1'b0}};
                else              res_o = full[W-1:0];
            end
            MODE_HALVE: res_o = full[W:1];
            default:    res_o = full[W-1:0];
        endcase
    end

    // Non-negative for signed or subtract, carry-out for unsigned add.
    always_comb ge_o = (sgn_i | sub_i) ? ~full[W+1] : full[W];
endmodule

// File: rtl/simd_word_sat.sv
// Full-word signed saturating add or subtract.
// Assumes two's-complement operands of width W.
module simd_word_sat #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o
);
    logic [W:0] full;

    // Exact sum with one guard bit, then clamp when the guard and sign differ.
    always_comb begin
        full = sub_i ? ({a_i[W-1], a_i} - {b_i[W-1], b_i})
                     : ({a_i[W-1], a_i} + {b_i[W-1], b_i});
        if (full[W] != full[W-1])
            res_o = full[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        else
            res_o = full[W-1:0];
    end
endmodule

// File: rtl/simd_bytesel.sv
// Byte-wise merge: byte i comes from a_i when sel_i[i] is set, else from b_i.
// Assumes one select bit per byte.
module simd_bytesel #(
    parameter int N = 4,
    parameter int BW = 8
) (
    input  logic [N*BW-1:0] a_i,
    input  logic [N*BW-1:0] b_i,
    input  logic [N-1:0]    sel_i,
    output logic [N*BW-1:0] res_o
);
    for (genvar i = 0; i < N; i++) begin : g_byte
        // Choose the source of one byte.
        assign res_o[i*BW +: BW] = sel_i[i] ? a_i[i*BW +: BW] : b_i[i*BW +: BW];
    end
endmodule

// File: rtl/simd_addsub.sv
// Packed SIMD add-subtract unit: byte and halfword lanes, exchange forms,
// 32-bit saturating add/subtract, byte select, stored greater-or-equal flags.
// Assumes the operation code is stable for the whole cycle it is issued in.
module simd_addsub
    import simd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    output logic [WORD_W-1:0] result_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              flag_we_o
);
    simd_op_t          op;
    logic [WORD_W-1:0] byte_res;
    logic [BYTE_N-1:0] byte_ge;
    logic [WORD_W-1:0] half_res;
    logic [FLAG_W-1:0] half_ge;
    logic [WORD_W-1:0] word_res;
    logic [WORD_W-1:0] sel_res;
    logic [FLAG_W-1:0] ge_next;
    logic [FLAG_W-1:0] flags_q;
    logic              reserved;

    assign op = simd_op_t'(op_i);

    for (genvar i = 0; i < BYTE_N; i++) begin : g_byte_lane
        simd_lane #(.W(BYTE_W)) u_lane (
            .a_i    (a_i[i*BYTE_W +: BYTE_W]),
            .b_i    (b_i[i*BYTE_W +: BYTE_W]),
            .sub_i  (op.kind == KIND_SUB),
            .sgn_i  (op.sgn),
            .mode_i (op.mode),
            .res_o  (byte_res[i*BYTE_W +: BYTE_W]),
            .ge_o   (byte_ge[i])
        );
    end

    for (genvar j = 0; j < HALF_N; j++) begin : g_half_lane
        localparam bit IS_TOP = (j == HALF_N - 1);
        localparam int MIRROR = HALF_N - 1 - j;
        logic [HALF_W-1:0] b_pick;
        logic              h_sub;
        logic              h_ge;

        // Exchange kinds take the opposite half of the second operand.
        assign b_pick = op.kind[1] ? b_i[MIRROR*HALF_W +: HALF_W] : b_i[j*HALF_W +: HALF_W];
        // Top lane adds under kind 2 and subtracts under kind 3; bottom is the reverse.
        assign h_sub  = (op.kind == KIND_SUB)
                      | ((op.kind == KIND_XAS) & !IS_TOP)
                      | ((op.kind == KIND_XSA) &  IS_TOP);

        simd_lane #(.W(HALF_W)) u_lane (
            .a_i    (a_i[j*HALF_W +: HALF_W]),
            .b_i    (b_pick),
            .sub_i  (h_sub),
            .sgn_i  (op.sgn),
            .mode_i (op.mode),
            .res_o  (half_res[j*HALF_W +: HALF_W]),
            .ge_o   (h_ge)
        );
        // One halfword flag covers both of its bytes.
        assign half_ge[j*BPH +: BPH] = {BPH{h_ge}};
    end

    simd_word_sat #(.W(WORD_W)) u_word (
        .a_i   (a_i),
        .b_i   (b_i),
        .sub_i (op.kind == KIND_SUB),
        .res_o (word_res)
    );

    simd_bytesel #(.N(BYTE_N), .BW(BYTE_W)) u_sel (
        .a_i   (a_i),
        .b_i   (b_i),
        .sel_i (flags_q),
        .res_o (sel_res)
    );

    // Flag reserved codes: special kind 3, or exchange kinds on byte lanes.
    always_comb reserved = (op.mode == MODE_SPEC) ? (op.kind == KIND_XSA)
                                                  : (!op.wide && op.kind[1]);

    // Steer the selected datapath to the result port.
    always_comb begin
        if (reserved)                  result_o = '0;
        else if (op.mode == MODE_SPEC) result_o = (op.kind == KIND_XAS) ? sel_res : word_res;
        else if (op.wide)              result_o = half_res;
        else                           result_o = byte_res;
    end

    // Candidate flags and the write condition for the flag register.
    always_comb begin
        ge_next   = op.wide ? half_ge : byte_ge;
        flag_we_o = valid_i && (op.mode == MODE_WRAP) && !reserved;
    end

    // Flag register: cleared on reset, loaded by wrapping lane operations.
    always_ff @(posedge clk) begin
        if (!rst_n)         flags_q <= '0;
        else if (flag_we_o) flags_q <= ge_next;
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/simd_addsub_chk.sv
// Property checker for simd_addsub, attached with bind below.
module simd_addsub_chk
    import simd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic [OP_W-1:0]   op_i,
    input logic [WORD_W-1:0] a_i,
    input logic [WORD_W-1:0] b_i,
    input logic [WORD_W-1:0] result_o,
    input logic [FLAG_W-1:0] flags_o,
    input logic              flag_we_o
);
    simd_op_t op;
    assign op = simd_op_t'(op_i);

    a_r8_reset_clear: assert property (@(posedge clk) !rst_n |=> flags_o == '0);

    a_r8_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we_o |=> $stable(flags_o));

    a_r8_write_source: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_o |-> (valid_i && op.mode == MODE_WRAP));

    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op.mode == MODE_SPEC && op.kind == KIND_XSA) |-> (result_o == '0 && !flag_we_o));

    a_r9_all_first: assert property (@(posedge clk) disable iff (!rst_n)
        (op.mode == MODE_SPEC && op.kind == KIND_XAS && flags_o == '1) |-> result_o == a_i);

    a_r9_all_second: assert property (@(posedge clk) disable iff (!rst_n)
        (op.mode == MODE_SPEC && op.kind == KIND_XAS && flags_o == '0) |-> result_o == b_i);

    a_r4_usat_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (op.mode == MODE_SAT && !op.sgn && op.wide && op.kind == KIND_ADD)
        |-> (result_o[31:16] >= a_i[31:16] && result_o[15:0] >= a_i[15:0]));

    a_r6_neg_stays_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (op.mode == MODE_SPEC && op.kind == KIND_ADD && a_i[31] && b_i[31]) |-> result_o[31]);
endmodule

bind simd_addsub simd_addsub_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .op_i      (op_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .result_o  (result_o),
    .flags_o   (flags_o),
    .flag_we_o (flag_we_o)
);

// File: tb/simd_addsub_bench.sv
module simd_addsub_bench;
    localparam int CLK_T = 10;
    localparam int NV    = 30;

    typedef struct packed {
        logic [5:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp;
    } vec_t;

    // Code layout: mode[5:4] sgn[3] wide[2] kind[1:0]
    localparam vec_t VECS [NV] = '{
        '{6'h08, 32'h87858381, 32'h08060402, 32'h8F8B8783}, // R1 signed add bytes
        '{6'h09, 32'h8F8B8783, 32'h08060402, 32'h87858381}, // R1 signed sub bytes
        '{6'h00, 32'h07050301, 32'h08060402, 32'h0F0B0703}, // R1 unsigned add bytes
        '{6'h01, 32'h0F0B0703, 32'h08060402, 32'h07050301}, // R1 unsigned sub bytes
        '{6'h0C, 32'h80038001, 32'h00040002, 32'h80078003}, // R2 plain halfword add
        '{6'h0E, 32'h80078003, 32'h00040002, 32'h80097FFF}, // R2 add-high/sub-low
        '{6'h0F, 32'h80038007, 32'h00020004, 32'h7FFF8009}, // R2 sub-high/add-low
        '{6'h06, 32'h80078003, 32'h00040002, 32'h80097FFF}, // R2 unsigned exchange
        '{6'h18, 32'h8085837F, 32'hFF060402, 32'h808B877F}, // R3 signed sat bytes
        '{6'h19, 32'h808B8783, 32'h08060402, 32'h80858381}, // R3 signed sat sub bytes
        '{6'h1E, 32'h80078003, 32'h00040002, 32'h80098000}, // R3 sat exchange
        '{6'h1C, 32'h80038000, 32'h00048002, 32'h80078000}, // R3 sat halfword add
        '{6'h14, 32'hFFFE0002, 32'h00020004, 32'hFFFF0006}, // R4 unsigned sat add
        '{6'h11, 32'h080B0702, 32'h0F060408, 32'h00050300}, // R4 unsigned sat sub bytes
        '{6'h16, 32'hFFF80003, 32'h00040009, 32'hFFFF0000}, // R4 unsigned sat exchange
        '{6'h17, 32'h0003FFF8, 32'h00090004, 32'h0000FFFF}, // R4 unsigned sat exchange 2
        '{6'h28, 32'h07050302, 32'h08060402, 32'h07050302}, // R5 signed halving add
        '{6'h29, 32'h8F8B8783, 32'h08060402, 32'hC3C2C1C0}, // R5 signed halving sub
        '{6'h21, 32'h0F0B0703, 32'h08060402, 32'h03020100}, // R5 unsigned halving sub
        '{6'h2C, 32'h80038001, 32'h00040002, 32'hC003C001}, // R5 floor rounding
        '{6'h2E, 32'h80078003, 32'h00040002, 32'hC004BFFF}, // R5 signed halving exchange
        '{6'h26, 32'h80078003, 32'h00040002, 32'h40043FFF}, // R5 carry kept
        '{6'h27, 32'h80038007, 32'h00020004, 32'h3FFF4004}, // R5 borrow kept
        '{6'h30, 32'h80000003, 32'h00000004, 32'h80000007}, // R6 word add no clamp
        '{6'h30, 32'h80000000, 32'h80000002, 32'h80000000}, // R6 word add low clamp
        '{6'h31, 32'h80000003, 32'h00000004, 32'h80000000}, // R6 word sub low clamp
        '{6'h31, 32'h80000003, 32'h00000002, 32'h80000001}, // R6 word sub no clamp
        '{6'h30, 32'h7FFFFFFF, 32'h00000001, 32'h7FFFFFFF}, // R6 word add high clamp
        '{6'h33, 32'h12345678, 32'h9ABCDEF0, 32'h00000000}, // R10 reserved special
        '{6'h0A, 32'h12345678, 32'h9ABCDEF0, 32'h00000000}  // R10 byte exchange
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        valid_i;
    logic [5:0]  op_i;
    logic [31:0] a_i;
    logic [31:0] b_i;
    logic [31:0] result_o;
    logic [3:0]  flags_o;
    logic        flag_we_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_T/2) clk = ~clk;

    simd_addsub u_simd_addsub (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (valid_i),
        .op_i      (op_i),
        .a_i       (a_i),
        .b_i       (b_i),
        .result_o  (result_o),
        .flags_o   (flags_o),
        .flag_we_o (flag_we_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one operation just after a falling edge and let it settle.
    task automatic issue(input logic v, input logic [5:0] op, input logic [31:0] a,
                         input logic [31:0] b);
        @(negedge clk);
        valid_i = v; op_i = op; a_i = a; b_i = b;
        #1;
    endtask

    // Issue a flag-producing op, check the write strobe, then the stored flags.
    task automatic load_flags(input string tag, input logic [5:0] op, input logic [31:0] a,
                              input logic [31:0] b, input logic [3:0] exp);
        issue(1'b1, op, a, b);
        chk({tag, " write strobe"}, {31'd0, flag_we_o}, 32'd1);
        @(negedge clk);
        valid_i = 1'b0;
        #1;
        chk({tag, " stored flags"}, {28'd0, flags_o}, {28'd0, exp});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_T * 100000);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; valid_i = 1'b0; op_i = '0; a_i = '0; b_i = '0;
        repeat (3) @(negedge clk);
        chk("R8 reset value", {28'd0, flags_o}, 32'd0);
        rst_n = 1'b1;

        // Table walk with valid low: results only, flags must not move.
        for (int k = 0; k < NV; k++) begin
            issue(1'b0, VECS[k].op, VECS[k].a, VECS[k].b);
            chk($sformatf("vector %0d result", k), result_o, VECS[k].exp);
        end
        @(negedge clk);
        chk("R8 no load without valid", {28'd0, flags_o}, 32'd0);

        // R7 / R9: signed byte flags followed by byte select.
        load_flags("R7 sadd8 all negative", 6'h08, 32'h80808080, 32'h0, 4'h0);
        issue(1'b0, 6'h32, 32'h33221100, 32'h77665544);
        chk("R9 select flags 0", result_o, 32'h77665544);
        load_flags("R7 sadd8 byte0 zero", 6'h08, 32'h80808000, 32'h0, 4'h1);
        issue(1'b0, 6'h32, 32'h33221100, 32'h77665544);
        chk("R9 select flags 1", result_o, 32'h77665500);
        load_flags("R7 sadd8 byte1 zero", 6'h08, 32'h80800080, 32'h0, 4'h2);
        issue(1'b0, 6'h32, 32'h33221100, 32'h77665544);
        chk("R9 select flags 2", result_o, 32'h77661144);

        // R7: unsigned halfword carry and unsigned byte no-borrow.
        load_flags("R7 uadd16 carry high", 6'h04, 32'hFFFE0002, 32'h00020004, 4'hC);
        load_flags("R7 usub8 borrow edges", 6'h01, 32'h080B0702, 32'h0F060408, 4'h6);
        issue(1'b0, 6'h32, 32'hAABBCCDD, 32'h11223344);
        chk("R9 select flags 6", result_o, 32'h11BBCC44);

        // R8: saturating op with valid high writes nothing.
        issue(1'b1, 6'h18, 32'h01010101, 32'h01010101);
        chk("R8 sat op strobe", {31'd0, flag_we_o}, 32'd0);
        @(negedge clk);
        chk("R8 sat op keeps flags", {28'd0, flags_o}, 32'h6);

        // R10: reserved code with valid high writes nothing.
        issue(1'b1, 6'h0B, 32'hFFFFFFFF, 32'h0);
        chk("R10 reserved strobe", {31'd0, flag_we_o}, 32'd0);
        chk("R10 reserved result", result_o, 32'h0);
        @(negedge clk);
        chk("R10 reserved keeps flags", {28'd0, flags_o}, 32'h6);

        // R8: synchronous reset in mid-run clears the flags.
        valid_i = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 mid-run reset", {28'd0, flags_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end
endmodule